// File: doc/BRIEF.md
# Binary Threshold Neuron with Integer Weights

This block is one neuron for networks that work on binary data. Each input is a single bit. Each weight is a small signed integer in sign-magnitude form, with a separate sign bit and magnitude field. Because an input can only be 0 or 1, the neuron needs no multiplier. It ANDs the input with every magnitude bit and with the sign bit. The gated terms are then added or subtracted according to their signs, together with a sign-magnitude bias, to give a signed net value.

A hard-limit activation turns the net value into the output. The output is 1 when the net is zero or positive, and 0 when the net is negative. This is the same as the inverted sign bit of the net. Weights and bias come in on ports that are expected to be tied to constants after offline training.

The number of inputs, the weight magnitude width and the bias magnitude width are parameters. The accumulator width is derived from them. A parameter chooses whether the output is registered or purely combinational.

Top module: `thr_neuron`

## Requirements
- R1: An input at 0 contributes zero to the net, whatever its weight magnitude and sign bit.
- R2: An input at 1 contributes its weight. The weight for input j is the magnitude in `w_mag_i[j*MAG_W +: MAG_W]`, made negative when `w_sign_i[j]` is 1 and kept positive when it is 0.
- R3: `net_o` is the two's complement sum of all input contributions plus the bias. It never overflows, even with every input at 1 and every magnitude at its maximum with the same sign.
- R4: The activation is 1 when net is >= 0 and 0 when net is negative.
- R5: A net of exactly zero gives an activation of 1. This includes cases where the zero comes from negative-zero codes, meaning sign bit 1 with magnitude 0.
- R6: With REG_OUT=1, `y_o` takes the activation of the inputs at each rising clock edge. While `rst_ni` is low, `y_o` is forced to 0 asynchronously.
- R7: `y_o` is the inverse of the sign bit of the net value: combinationally when REG_OUT=0, or one clock later when REG_OUT=1.
- R8: The bias value is `b_mag_i`, made negative when `b_sign_i` is 1. A negative-zero bias counts as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_i | input | N_IN | Binary inputs |
| w_mag_i | input | N_IN*MAG_W | Weight magnitudes; input j uses field j |
| w_sign_i | input | N_IN | Weight sign bits, 1 means negative |
| b_mag_i | input | B_MAG_W | Bias magnitude |
| b_sign_i | input | 1 | Bias sign, 1 means negative |
| net_o | output | ACC_W | Signed net value, two's complement |
| y_o | output | 1 | Hard-limit output |

## Verification
The vector table covers a wide range of input patterns:
- All inputs low, to show that gating removes every weight, including negative ones.
- All inputs high with every magnitude at its maximum and every sign the same, which reaches both ends of the accumulator range.
- Alternating input masks over a ramp of weight magnitudes, which shows which field goes with which input.
- Mixed-sign patterns that cancel to exactly zero or miss zero by one. These separate the >= 0 decision from a strict > 0 decision.
- Negative-zero weights and bias, which must still count as zero.

Directed steps after the table check the one-cycle output latency and the asynchronous clear.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

  // width of a signed accumulator able to hold +/-(n*(2^mw-1) + 2^bw-1)
  function automatic int acc_width(input int n, input int mw, input int bw);
    longint max_abs;
    int w;
    max_abs = longint'(n) * ((longint'(1) << mw) - 1) + ((longint'(1) << bw) - 1);
    w = 1;
    while ((longint'(1) << w) <= max_abs) w++;
    return w + 1;
  endfunction

  function automatic longint max_net(input int n, input int mw, input int bw);
    return longint'(n) * ((longint'(1) << mw) - 1) + ((longint'(1) << bw) - 1);
  endfunction

endpackage

// File: rtl/nrn_term.sv
module nrn_term #(
  parameter int MAG_W = 3,
  parameter int ACC_W = 8
) (
  input  logic                    x_i,
  input  logic [MAG_W-1:0]        mag_i,
  input  logic                    sign_i,
  output logic signed [ACC_W-1:0] term_o
);
  logic [MAG_W-1:0]        mag_g;
  logic                    neg_g;
  logic signed [ACC_W-1:0] ext;

  // AND gating replaces the multiply for a 0/1 input
  assign mag_g = mag_i & {MAG_W{x_i}};
  assign neg_g = sign_i & x_i;
  assign ext   = signed'({{(ACC_W-MAG_W){1'b0}}, mag_g});

  // -0 folds to 0 in two's complement
  assign term_o = neg_g ? -ext : ext;
endmodule

// File: rtl/nrn_sum.sv
module nrn_sum #(
  parameter int N_IN  = 8,
  parameter int ACC_W = 8
) (
  input  logic [N_IN*ACC_W-1:0]   terms_i,
  input  logic signed [ACC_W-1:0] bias_i,
  output logic signed [ACC_W-1:0] net_o
);
  logic signed [ACC_W-1:0] part [N_IN+1];

  assign part[0] = bias_i;

  for (genvar j = 0; j < N_IN; j++) begin : g_acc
    assign part[j+1] = part[j] + signed'(terms_i[j*ACC_W +: ACC_W]);
  end

  assign net_o = part[N_IN];
endmodule

// File: rtl/nrn_act.sv
module nrn_act #(
  parameter int ACC_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ACC_W-1:0] net_i,
  output logic                    y_o
);
  logic y_d;

  // hard limit: zero counts as non-negative
  assign y_d = ~net_i[ACC_W-1];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) y_o <= 1'b0;
      else         y_o <= y_d;
    end
  end else begin : g_comb
    assign y_o = y_d;
  end
endmodule

// File: rtl/thr_neuron.sv
module thr_neuron #(
  parameter int N_IN    = 8,
  parameter int MAG_W   = 3,
  parameter int B_MAG_W = 5,
  parameter bit REG_OUT = 1'b1,
  localparam int ACC_W  = neuron_pkg::acc_width(N_IN, MAG_W, B_MAG_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IN-1:0]         x_i,
  input  logic [N_IN*MAG_W-1:0]   w_mag_i,
  input  logic [N_IN-1:0]         w_sign_i,
  input  logic [B_MAG_W-1:0]      b_mag_i,
  input  logic                    b_sign_i,
  output logic signed [ACC_W-1:0] net_o,
  output logic                    y_o
);
  logic [N_IN*ACC_W-1:0]   terms;
  logic signed [ACC_W-1:0] bias_t;
  logic signed [ACC_W-1:0] net;

  for (genvar j = 0; j < N_IN; j++) begin : g_term
    nrn_term #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_term (
      .x_i   (x_i[j]),
      .mag_i (w_mag_i[j*MAG_W +: MAG_W]),
      .sign_i(w_sign_i[j]),
      .term_o(terms[j*ACC_W +: ACC_W])
    );
  end

  // bias is a term whose input is tied high
  nrn_term #(.MAG_W(B_MAG_W), .ACC_W(ACC_W)) u_bias (
    .x_i   (1'b1),
    .mag_i (b_mag_i),
    .sign_i(b_sign_i),
    .term_o(bias_t)
  );

  nrn_sum #(.N_IN(N_IN), .ACC_W(ACC_W)) u_sum (
    .terms_i(terms),
    .bias_i (bias_t),
    .net_o  (net)
  );

  nrn_act #(.ACC_W(ACC_W), .REG_OUT(REG_OUT)) u_act (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .net_i (net),
    .y_o   (y_o)
  );

  assign net_o = net;
endmodule

// File: rtl/thr_neuron_chk.sv
module thr_neuron_chk #(
  parameter int N_IN    = 8,
  parameter int MAG_W   = 3,
  parameter int B_MAG_W = 5,
  parameter bit REG_OUT = 1'b1,
  parameter int ACC_W   = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_IN-1:0]         x_i,
  input logic [B_MAG_W-1:0]      b_mag_i,
  input logic signed [ACC_W-1:0] net_o,
  input logic                    y_o
);
  localparam longint MAXN = neuron_pkg::max_net(N_IN, MAG_W, B_MAG_W);

  p_zero_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0 && b_mag_i == '0) |-> net_o == '0);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(net_o) <= MAXN) && (longint'(net_o) >= -MAXN));

  if (REG_OUT) begin : g_seq
    p_neg_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (net_o < 0) |=> !y_o);
    p_zero_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (net_o == '0) |=> y_o);
    p_reset_low_r6: assert property (@(posedge clk_i)
      !rst_ni |-> !y_o);
    p_inv_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (y_o == !$past(net_o[ACC_W-1])));
  end else begin : g_comb
    always_comb begin
      a_inv_sign_r7: assert (y_o == !net_o[ACC_W-1]);
    end
  end
endmodule

bind thr_neuron thr_neuron_chk #(
  .N_IN(N_IN), .MAG_W(MAG_W), .B_MAG_W(B_MAG_W), .REG_OUT(REG_OUT), .ACC_W(ACC_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .x_i    (x_i),
  .b_mag_i(b_mag_i),
  .net_o  (net_o),
  .y_o    (y_o)
);

// File: tb/sim_thr_neuron.sv
module sim_thr_neuron;
  localparam int N_IN = 8, MAG_W = 3, B_MAG_W = 5;

  typedef struct packed {
    logic [7:0]        x;
    logic [23:0]       wm;
    logic [7:0]        ws;
    logic [4:0]        bm;
    logic              bs;
    logic signed [7:0] net;
  } vec_t;

  // input j magnitude field is wm[3j+2:3j]; sign 1 = negative
  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{8'h00, 24'hFFFFFF, 8'h00, 5'd0,  1'b0,  8'sd0},   // R1 R5
    '{8'hFF, 24'hFFFFFF, 8'h00, 5'd31, 1'b0,  8'sd87},  // R3 max
    '{8'hFF, 24'hFFFFFF, 8'hFF, 5'd31, 1'b1, -8'sd87},  // R3 min
    '{8'h00, 24'hFFFFFF, 8'hFF, 5'd0,  1'b1,  8'sd0},   // R1 R8 -0 bias
    '{8'h01, 24'h000005, 8'h00, 5'd5,  1'b1,  8'sd0},   // R2 R5
    '{8'h01, 24'h000005, 8'h01, 5'd4,  1'b0, -8'sd1},   // R2 R4
    '{8'h80, 24'h600000, 8'h80, 5'd3,  1'b0,  8'sd0},   // R2 top field
    '{8'h0F, 24'hFFFFFF, 8'h05, 5'd1,  1'b1, -8'sd1},   // R2 R4 mixed
    '{8'hF0, 24'hFFFFFF, 8'h0F, 5'd28, 1'b1,  8'sd0},   // R1 gated neg
    '{8'hAA, 24'hFAC688, 8'h00, 5'd17, 1'b1, -8'sd1},   // R2 ramp odd
    '{8'h55, 24'hFAC688, 8'h40, 5'd0,  1'b0,  8'sd0},   // R2 ramp even
    '{8'hFF, 24'hFAC688, 8'h00, 5'd0,  1'b1,  8'sd28},  // R2 R8
    '{8'hFF, 24'h000000, 8'hFF, 5'd0,  1'b0,  8'sd0}    // R5 -0 weights
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_IN-1:0] x;
  logic [N_IN*MAG_W-1:0] wm;
  logic [N_IN-1:0] ws;
  logic [B_MAG_W-1:0] bm;
  logic bs;
  logic signed [7:0] net;
  logic y;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  thr_neuron #(.N_IN(N_IN), .MAG_W(MAG_W), .B_MAG_W(B_MAG_W), .REG_OUT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .x_i(x), .w_mag_i(wm), .w_sign_i(ws),
    .b_mag_i(bm), .b_sign_i(bs), .net_o(net), .y_o(y)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    x = v.x; wm = v.wm; ws = v.ws; bm = v.bm; bs = v.bs;
  endtask

  initial begin
    drive(TBL[1]);
    #1;
    chk("R6 reset y", int'(y), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) drive(TBL[i]);
      #1 chk("R3 net", int'(net), int'(TBL[i].net));
      @(posedge clk) #1;
      chk("R4 R5 R7 y", int'(y), (TBL[i].net >= 0) ? 1 : 0);
    end

    // R6 latency: old value holds until the edge
    @(negedge clk) drive(TBL[5]);
    @(posedge clk) #1 chk("R6 y low", int'(y), 0);
    @(negedge clk) drive(TBL[1]);
    #1 chk("R6 y held", int'(y), 0);
    chk("R3 net comb", int'(net), 87);
    @(posedge clk) #1 chk("R6 y rises", int'(y), 1);

    // R6 asynchronous clear mid-cycle
    @(negedge clk) rst_ni = 1'b0;
    #1 chk("R6 async clear", int'(y), 0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk) #1 chk("R6 after release", int'(y), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule